// File: doc/BRIEF.md
# Alternate Bus Master Acquisition FSM

This block sits inside a device that occasionally needs to take over a shared parallel bus from the resident master. When the device's local client raises its need, the block pulls the open-drain bus request line low. Once a grant is seen, it watches the bus until the previous transfer has fully wound down. Then it pulls the open-drain grant acknowledge line low and tells the local client that it owns the bus. It keeps ownership until the client reports that every transfer it needs has finished. It then lets go of acknowledge for one cycle of cleanup before going back to rest.

The grant, address strobe, the two transfer-acknowledge lines and the shared acknowledge line are all active-low. Each arrives from another clock domain and passes through a two-flop synchronizer. Both open-drain lines are modelled as active-high pull enables, so the block only ever pulls a line low and several requesters can share it. A parameter selects a simple mode in which only address strobe decides whether the bus is free.

There are five states. IDLE goes to REQUEST when need is high. REQUEST goes back to IDLE when need drops before a grant, and goes to WAIT_IDLE on a grant. WAIT_IDLE goes to OWN once the bus is seen free. OWN goes to RELEASE on done. RELEASE always goes to IDLE after one cycle. All other cases hold the current state.

Top module: `bus_master_acq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, req_pull_o, ack_pull_o and owner_o are all low and the machine is in IDLE.
- R2: In IDLE with need_i high, req_pull_o goes high after the next rising edge (REQUEST).
- R3: If need_i is low in REQUEST before a grant has been seen, req_pull_o goes low after the next edge (IDLE), and ack_pull_o is not asserted.
- R4: grant_n_i, strobe_n_i, xack0_n_i, xack1_n_i and shared_ack_n_i are active-low (0 = asserted). Each passes through two synchronizer flops, so a change applied between edges is acted on at the third rising edge after it is applied.
- R5: With STROBE_ONLY=0, WAIT_IDLE keeps ack_pull_o low and req_pull_o high while any of strobe_n_i, xack0_n_i, xack1_n_i or shared_ack_n_i is low. It moves to OWN once all four are high.
- R6: With STROBE_ONLY=1, only strobe_n_i decides whether the bus is free. Low levels on xack0_n_i, xack1_n_i and shared_ack_n_i do not delay OWN.
- R7: In OWN, ack_pull_o is high and req_pull_o is low. owner_o equals ack_pull_o in every cycle and is high only in OWN.
- R8: OWN is left only when done_i is high. ack_pull_o stays high while done_i is low, even if need_i drops or the grant is withdrawn.
- R9: done_i in OWN leads to exactly one RELEASE cycle with ack_pull_o and req_pull_o low, then IDLE. If need_i is still high, req_pull_o rises one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_i | input | 1 | Local client wants the bus (synchronous) |
| done_i | input | 1 | Local client has completed all of its transfers |
| grant_n_i | input | 1 | Bus grant, active-low, asynchronous |
| strobe_n_i | input | 1 | Address strobe, active-low, asynchronous |
| xack0_n_i | input | 1 | Transfer acknowledge 0, active-low, asynchronous |
| xack1_n_i | input | 1 | Transfer acknowledge 1, active-low, asynchronous |
| shared_ack_n_i | input | 1 | Shared grant acknowledge line as observed, active-low |
| req_pull_o | output | 1 | Pull the open-drain request line low |
| ack_pull_o | output | 1 | Pull the open-drain grant acknowledge line low |
| owner_o | output | 1 | Tells the local client that this device is bus master |

## Verification
The outputs are decoded directly from the state register, so a wrong state shows up at the pins on the same cycle it is entered. A stray OWN shows as owner_o and ack_pull_o high. A missed OWN leaves req_pull_o high with no acknowledge. A stuck RELEASE or REQUEST shows as a missing request on the cycle after it was due. Faults in the idle qualifier are detected by releasing the busy lines one at a time and checking that acknowledge appears exactly three edges after the last one clears. Faults in the synchronizer depth are caught by sampling one edge before and one edge at that point.

// File: rtl/bma_pkg.sv
package bma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REQUEST   = 3'd1,
        ST_WAIT_IDLE = 3'd2,
        ST_OWN       = 3'd3,
        ST_RELEASE   = 3'd4
    } acq_state_e;

    localparam int unsigned ASYNC_LINES = 5;

endpackage

// File: rtl/bma_sync.sv
module bma_sync #(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/bma_idle_qual.sv
module bma_idle_qual #(
    parameter bit STROBE_ONLY = 1'b0
) (
    input  logic strobe_n_s,
    input  logic xack0_n_s,
    input  logic xack1_n_s,
    input  logic shared_n_s,
    output logic bus_idle
);

    logic all_quiet;

    assign all_quiet = strobe_n_s & xack0_n_s & xack1_n_s & shared_n_s;
    assign bus_idle  = STROBE_ONLY ? strobe_n_s : all_quiet;

endmodule

// File: rtl/bma_fsm.sv
module bma_fsm
    import bma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       need,
    input  logic       done,
    input  logic       grant_seen,
    input  logic       bus_idle,
    output acq_state_e state_o,
    output logic       req_pull,
    output logic       ack_pull,
    output logic       owner
);

    acq_state_e state_q;
    acq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (need) state_d = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (!need)          state_d = ST_IDLE;
                else if (grant_seen) state_d = ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: begin
                if (bus_idle) state_d = ST_OWN;
            end
            ST_OWN: begin
                if (done) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_pull = 1'b0;
        ack_pull = 1'b0;
        owner    = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_REQUEST:   req_pull = 1'b1;
            ST_WAIT_IDLE: req_pull = 1'b1;
            ST_OWN: begin
                ack_pull = 1'b1;
                owner    = 1'b1;
            end
            ST_RELEASE:   ;
            default:      ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bus_master_acq.sv
module bus_master_acq
    import bma_pkg::*;
#(
    parameter bit          STROBE_ONLY = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_i,
    input  logic done_i,
    input  logic grant_n_i,
    input  logic strobe_n_i,
    input  logic xack0_n_i,
    input  logic xack1_n_i,
    input  logic shared_ack_n_i,
    output logic req_pull_o,
    output logic ack_pull_o,
    output logic owner_o
);

    localparam int unsigned NLINES = ASYNC_LINES;

    logic [NLINES-1:0] raw_n;
    logic [NLINES-1:0] sync_n;
    logic              grant_seen;
    logic              bus_idle;
    acq_state_e        state;

    assign raw_n = {shared_ack_n_i, xack1_n_i, xack0_n_i, strobe_n_i, grant_n_i};

    bma_sync #(
        .WIDTH   (NLINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NLINES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_n),
        .dout (sync_n)
    );

    assign grant_seen = ~sync_n[0];

    bma_idle_qual #(
        .STROBE_ONLY(STROBE_ONLY)
    ) u_qual (
        .strobe_n_s(sync_n[1]),
        .xack0_n_s (sync_n[2]),
        .xack1_n_s (sync_n[3]),
        .shared_n_s(sync_n[4]),
        .bus_idle  (bus_idle)
    );

    bma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .need      (need_i),
        .done      (done_i),
        .grant_seen(grant_seen),
        .bus_idle  (bus_idle),
        .state_o   (state),
        .req_pull  (req_pull_o),
        .ack_pull  (ack_pull_o),
        .owner     (owner_o)
    );

endmodule

// File: rtl/bma_checker.sv
module bma_checker
    import bma_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       need_i,
    input logic       done_i,
    input logic       grant_seen,
    input logic       bus_idle,
    input acq_state_e state,
    input logic       req_pull_o,
    input logic       ack_pull_o,
    input logic       owner_o
);

    // R2
    a_r2_request_follows_need: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && need_i) |=> req_pull_o);

    // R3
    a_r3_cancel_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQUEST && !need_i) |=> (!req_pull_o && !ack_pull_o));

    // R5
    a_r5_ack_only_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pull_o) |-> $past(bus_idle));

    // R7
    a_r7_owner_matches_ack: assert property (@(posedge clk) disable iff (!rst_n)
        owner_o == ack_pull_o);

    // R7
    a_r7_no_req_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pull_o |-> !req_pull_o);

    // R8
    a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pull_o && !done_i) |=> ack_pull_o);

    // R9
    a_r9_release_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_pull_o) |=> (!ack_pull_o && !req_pull_o));

    // R4: a grant is never acted on before it is seen
    a_r4_wait_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQUEST && !grant_seen) |=> state != ST_WAIT_IDLE);

endmodule

bind bus_master_acq bma_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .need_i    (need_i),
    .done_i    (done_i),
    .grant_seen(grant_seen),
    .bus_idle  (bus_idle),
    .state     (state),
    .req_pull_o(req_pull_o),
    .ack_pull_o(ack_pull_o),
    .owner_o   (owner_o)
);

// File: tb/bus_master_acq_tb_top.sv
`timescale 1ns/1ps
module bus_master_acq_tb_top;

    localparam int NVEC = 10;

    // {need, done, grant_n, strobe_n, xack0_n, xack1_n, shared_n,
    //  main_req, main_ack, strobe_only_req, strobe_only_ack}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0_0_1_1_1_1_1_0_0_0_0,
        11'b1_0_1_1_1_1_1_1_0_1_0,
        11'b1_0_0_0_0_1_1_1_0_1_0,
        11'b1_0_0_1_0_1_1_1_0_0_1,
        11'b1_0_0_1_1_0_1_1_0_0_1,
        11'b1_0_0_1_1_1_0_1_0_0_1,
        11'b1_0_0_1_1_1_1_0_1_0_1,
        11'b0_0_1_1_1_1_1_0_1_0_1,
        11'b0_1_1_1_1_1_1_0_0_0_0,
        11'b0_0_1_1_1_1_1_0_0_0_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic need = 1'b0, done = 1'b0;
    logic grant_n = 1'b1, strobe_n = 1'b1, xack0_n = 1'b1, xack1_n = 1'b1, shared_n = 1'b1;
    logic m_req, m_ack, m_own, s_req, s_ack, s_own;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bus_master_acq #(.STROBE_ONLY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .need_i(need), .done_i(done),
        .grant_n_i(grant_n), .strobe_n_i(strobe_n), .xack0_n_i(xack0_n),
        .xack1_n_i(xack1_n), .shared_ack_n_i(shared_n),
        .req_pull_o(m_req), .ack_pull_o(m_ack), .owner_o(m_own)
    );

    bus_master_acq #(.STROBE_ONLY(1'b1)) dut_so_i (
        .clk(clk), .rst_n(rst_n), .need_i(need), .done_i(done),
        .grant_n_i(grant_n), .strobe_n_i(strobe_n), .xack0_n_i(xack0_n),
        .xack1_n_i(xack1_n), .shared_ack_n_i(shared_n),
        .req_pull_o(s_req), .ack_pull_o(s_ack), .owner_o(s_own)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        tick(3);
        chk("R1 req in reset", m_req, 1'b0);
        chk("R1 ack in reset", m_ack, 1'b0);
        chk("R1 owner in reset", m_own, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 req after reset", m_req, 1'b0);

        // Vector table: R4, R5, R6, R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            {need, done, grant_n, strobe_n, xack0_n, xack1_n, shared_n} = VEC[v][10:4];
            tick(4);
            chk($sformatf("R5 R7 v%0d main req", v), m_req, VEC[v][3]);
            chk($sformatf("R5 R8 v%0d main ack", v), m_ack, VEC[v][2]);
            chk($sformatf("R7 v%0d main owner", v), m_own, VEC[v][2]);
            chk($sformatf("R6 v%0d strobe-only req", v), s_req, VEC[v][1]);
            chk($sformatf("R6 R8 v%0d strobe-only ack", v), s_ack, VEC[v][0]);
            chk($sformatf("R7 v%0d strobe-only owner", v), s_own, VEC[v][0]);
        end

        // R2: request one edge after need
        need = 1'b1;
        tick(1);
        chk("R2 req after need", m_req, 1'b1);

        // R3: cancel before grant
        tick(2);
        need = 1'b0;
        tick(1);
        chk("R3 req dropped on cancel", m_req, 1'b0);
        chk("R3 no ack on cancel", m_ack, 1'b0);
        tick(5);
        chk("R3 still no ack", m_ack, 1'b0);
        chk("R3 still no req", m_req, 1'b0);

        // R4: synchronizer latency on strobe release
        grant_n  = 1'b0;
        strobe_n = 1'b0;
        need     = 1'b1;
        tick(6);
        chk("R5 waiting req", m_req, 1'b1);
        chk("R5 waiting ack", m_ack, 1'b0);
        strobe_n = 1'b1;
        tick(2);
        chk("R4 ack not yet", m_ack, 1'b0);
        tick(1);
        chk("R4 ack at third edge", m_ack, 1'b1);
        chk("R7 req low while owning", m_req, 1'b0);

        // R9: single release cycle, re-request with need still high
        done = 1'b1;
        tick(1);
        chk("R9 release ack", m_ack, 1'b0);
        chk("R9 release req", m_req, 1'b0);
        chk("R9 release owner", m_own, 1'b0);
        done = 1'b0;
        tick(1);
        chk("R9 idle req", m_req, 1'b0);
        tick(1);
        chk("R9 re-request", m_req, 1'b1);

        // R1: reset while owning
        tick(4);
        chk("R8 owning again", m_ack, 1'b1);
        rst_n = 1'b0;
        tick(1);
        chk("R1 ack cleared by reset", m_ack, 1'b0);
        chk("R1 owner cleared by reset", m_own, 1'b0);
        chk("R1 req cleared by reset", m_req, 1'b0);
        need  = 1'b0;
        rst_n = 1'b1;
        tick(2);

        finish_run();
    end

endmodule